// File: doc/BRIEF.md
# Telecom Clock Output Selector

This block derives four backplane telecom clock outputs from a single 77.76 MHz reference. A 16-bit control word holds one 4-bit selector for each output. A selector either leaves its output undriven or picks one of three rates: 8 kHz, 19.44 MHz or 2.048 MHz. Each output has its own enable line, which drives the tri-state buffer outside the block. The PLL that makes the reference and the pad buffers are not part of this block.

All rates come from the reference clock. 19.44 MHz is the reference divided by 4, and 8 kHz is the reference divided by 9720. 2.048 MHz comes from a phase accumulator. Its average frequency is exact, and each edge may be late by up to one reference period. A new selector value is not applied at once. It takes effect only at the next 8 kHz frame boundary, so a change of rate never produces a short pulse on an output.

Top module: `tclk_out_sel`

## Requirements
- R1: While reset is asserted, and after release until the first 8 kHz boundary, every enable is low and every clock output is low, whatever the control word holds.
- R2: Output k is controlled by bits [4k+3:4k] of the control word. Output 0 (clock 1) uses bits [3:0], and output 1 (clock 2) uses bits [7:4].
- R3: Selector code 0x0 holds the output's enable low and its clock low.
- R4: Code 0x1 drives 8 kHz with the enable high: exactly one rising edge in every 9720 reference cycles.
- R5: Code 0x2 drives 19.44 MHz with the enable high: a rising edge every 4 reference cycles, which gives 2430 edges in 9720 cycles.
- R6: Code 0x3 drives 2.048 MHz with the enable high: exactly 256 rising edges in every 9720 reference cycles, with rising edges 37 or 38 cycles apart.
- R7: Every code from 0x4 to 0xF drives 8 kHz with the enable high, exactly as code 0x1 does.
- R8: A new selector value is applied only at an 8 kHz frame boundary. The changed output's enable and clock switch in the same reference cycle in which an 8 kHz output rises, and they do not move before that cycle.
- R9: An output's enable is high exactly while its applied code is nonzero, and a clock whose enable is low stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 77.76 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel_word | input | 16 | Four 4-bit selectors; bits [4k+3:4k] control output k |
| tclk_o | output | 4 | Telecom clock outputs, one per selector |
| tclk_oe | output | 4 | Output-enable lines for the tri-state buffers |

## Verification
A frame counter that is out of step would move an enable at a time that does not match the rising edge of an 8 kHz output. The bench and the checker both see this within one 9720-cycle frame. A wrong divider state or accumulator step changes the count of rising edges in a frame-long window, or the spacing between edges, and the bench measures both over one frame. A clock that toggles while its enable is low is flagged by the checker in the cycle where it happens.

// File: rtl/tclk_pkg.sv
package tclk_pkg;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    TC_OFF = 4'h0,
    TC_8K  = 4'h1,
    TC_19M = 4'h2,
    TC_2M  = 4'h3
  } tclk_code_e;
endpackage

// File: rtl/tclk_rst_sync.sv
module tclk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tclk_rate_gen.sv
module tclk_rate_gen #(
  parameter int unsigned FRAME_DIV = 9720,
  parameter int unsigned FAST_DIV  = 4,
  parameter int unsigned ACC_STEP  = 64,
  parameter int unsigned ACC_MOD   = 1215
) (
  input  logic clk,
  input  logic rst_ni,
  output logic lvl_frame,
  output logic lvl_fast,
  output logic lvl_pcm,
  output logic frame_wrap
);
  localparam int unsigned FW = $clog2(FRAME_DIV);
  localparam int unsigned SW = (FAST_DIV > 2) ? $clog2(FAST_DIV) : 1;
  localparam int unsigned AW = $clog2(ACC_MOD + ACC_STEP);

  logic [FW-1:0] frame_q, frame_d;
  logic [SW-1:0] fast_q, fast_d;
  logic [AW-1:0] acc_q, acc_d, acc_sum;
  logic          pcm_q, pcm_d;
  logic          fast_wrap;

  // next state
  always_comb begin
    frame_wrap = (frame_q == FW'(FRAME_DIV - 1));
    fast_wrap  = (fast_q == SW'(FAST_DIV - 1));
    frame_d    = frame_wrap ? '0 : frame_q + 1'b1;
    fast_d     = fast_wrap ? '0 : fast_q + 1'b1;
    acc_sum    = acc_q + AW'(ACC_STEP);
    if (acc_sum >= AW'(ACC_MOD)) begin
      acc_d = acc_sum - AW'(ACC_MOD);
      pcm_d = ~pcm_q;
    end else begin
      acc_d = acc_sum;
      pcm_d = pcm_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      fast_q  <= '0;
      acc_q   <= '0;
      pcm_q   <= 1'b0;
    end else begin
      frame_q <= frame_d;
      fast_q  <= fast_d;
      acc_q   <= acc_d;
      pcm_q   <= pcm_d;
    end
  end

  assign lvl_frame = (frame_q < FW'(FRAME_DIV / 2));
  assign lvl_fast  = (fast_q < SW'(FAST_DIV / 2));
  assign lvl_pcm   = pcm_q;
endmodule

// File: rtl/tclk_out_chan.sv
module tclk_out_chan
  import tclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              frame_wrap,
  input  logic [CODE_W-1:0] code_req,
  input  logic              lvl_frame,
  input  logic              lvl_fast,
  input  logic              lvl_pcm,
  output logic              clk_o,
  output logic              oe_o
);
  logic [CODE_W-1:0] active_q, active_d;
  logic              out_q, out_d;
  logic              oe_q, oe_d;

  // next state: selection latched only at frame boundary
  always_comb begin
    active_d = frame_wrap ? code_req : active_q;
    oe_d     = (active_q != CODE_W'(TC_OFF));
    case (active_q)
      CODE_W'(TC_OFF): out_d = 1'b0;
      CODE_W'(TC_19M): out_d = lvl_fast;
      CODE_W'(TC_2M):  out_d = lvl_pcm;
      default:         out_d = lvl_frame;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      out_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      out_q    <= out_d;
      oe_q     <= oe_d;
    end
  end

  assign clk_o = out_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/tclk_out_sel.sv
module tclk_out_sel
  import tclk_pkg::*;
#(
  parameter int unsigned NUM_OUT   = 4,
  parameter int unsigned FRAME_DIV = 9720,
  parameter int unsigned FAST_DIV  = 4,
  parameter int unsigned ACC_STEP  = 64,
  parameter int unsigned ACC_MOD   = 1215
) (
  input  logic                      clk_ref,
  input  logic                      rst_n,
  input  logic [NUM_OUT*CODE_W-1:0] sel_word,
  output logic [NUM_OUT-1:0]        tclk_o,
  output logic [NUM_OUT-1:0]        tclk_oe
);
  logic rst_ni;
  logic lvl_frame, lvl_fast, lvl_pcm, frame_wrap;

  tclk_rst_sync u_rst (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .rst_no (rst_ni)
  );

  tclk_rate_gen #(
    .FRAME_DIV (FRAME_DIV),
    .FAST_DIV  (FAST_DIV),
    .ACC_STEP  (ACC_STEP),
    .ACC_MOD   (ACC_MOD)
  ) u_rates (
    .clk        (clk_ref),
    .rst_ni     (rst_ni),
    .lvl_frame  (lvl_frame),
    .lvl_fast   (lvl_fast),
    .lvl_pcm    (lvl_pcm),
    .frame_wrap (frame_wrap)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_ch
    tclk_out_chan u_ch (
      .clk        (clk_ref),
      .rst_ni     (rst_ni),
      .frame_wrap (frame_wrap),
      .code_req   (sel_word[k*CODE_W +: CODE_W]),
      .lvl_frame  (lvl_frame),
      .lvl_fast   (lvl_fast),
      .lvl_pcm    (lvl_pcm),
      .clk_o      (tclk_o[k]),
      .oe_o       (tclk_oe[k])
    );
  end
endmodule

// File: rtl/tclk_out_sel_chk.sv
module tclk_out_sel_chk #(
  parameter int unsigned NUM_OUT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_OUT-1:0] tclk_o,
  input logic [NUM_OUT-1:0] tclk_oe,
  input logic               frame_wrap
);
  // R9
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tclk_o & ~tclk_oe) == '0);

  // R8
  oe_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tclk_oe) |-> $past(frame_wrap, 2));

  // R8
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> !frame_wrap);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tclk_oe == '0 && tclk_o == '0));
endmodule

bind tclk_out_sel tclk_out_sel_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk        (clk_ref),
  .rst_n      (rst_n),
  .tclk_o     (tclk_o),
  .tclk_oe    (tclk_oe),
  .frame_wrap (frame_wrap)
);

// File: tb/tb_tclk_out_sel.sv
module tb_tclk_out_sel;
  localparam int FRAME = 9720;

  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic [15:0] sel_word;
  logic [3:0]  tclk_o;
  logic [3:0]  tclk_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk_ref = ~clk_ref;

  tclk_out_sel dut (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .sel_word (sel_word),
    .tclk_o   (tclk_o),
    .tclk_oe  (tclk_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int rises[4], highs[4], min_iv[4], max_iv[4], last_r[4];

  task automatic measure_frame();
    logic [3:0] prev;
    for (int i = 0; i < 4; i++) begin
      rises[i] = 0; highs[i] = 0; min_iv[i] = 1 << 30; max_iv[i] = 0; last_r[i] = -1;
    end
    @(negedge clk_ref);
    prev = tclk_o;
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk_ref);
      for (int i = 0; i < 4; i++) begin
        if (tclk_o[i]) highs[i]++;
        if (tclk_o[i] && !prev[i]) begin
          rises[i]++;
          if (last_r[i] >= 0) begin
            if (c - last_r[i] < min_iv[i]) min_iv[i] = c - last_r[i];
            if (c - last_r[i] > max_iv[i]) max_iv[i] = c - last_r[i];
          end
          last_r[i] = c;
        end
      end
      prev = tclk_o;
    end
  endtask

  // R1: reset state and hold until first boundary
  task automatic t_reset();
    rst_n = 1'b0;
    sel_word = 16'h3333;
    repeat (5) @(negedge clk_ref);
    chk(tclk_oe == 4'h0, "R1 oe in reset", int'(tclk_oe), 0);
    chk(tclk_o == 4'h0, "R1 clk in reset", int'(tclk_o), 0);
    rst_n = 1'b1;
    begin
      int viol = 0;
      repeat (200) begin
        @(negedge clk_ref);
        if (tclk_oe != 4'h0 || tclk_o != 4'h0) viol++;
      end
      chk(viol == 0, "R1 quiet after release", viol, 0);
    end
  endtask

  // R2..R7, R9: per-nibble rate selection
  task automatic t_pattern(input logic [15:0] w);
    sel_word = w;
    repeat (2 * FRAME + 10) @(negedge clk_ref);
    measure_frame();
    for (int i = 0; i < 4; i++) begin
      int code = int'(w[4*i +: 4]);
      case (code)
        0: begin
          chk(tclk_oe[i] == 1'b0, $sformatf("R3 R9 R2 out%0d oe", i), int'(tclk_oe[i]), 0);
          chk(highs[i] == 0, $sformatf("R3 R9 out%0d high cycles", i), highs[i], 0);
        end
        2: begin
          chk(tclk_oe[i] == 1'b1, $sformatf("R5 R2 out%0d oe", i), int'(tclk_oe[i]), 1);
          chk(rises[i] == 2430, $sformatf("R5 R2 out%0d edges", i), rises[i], 2430);
          chk(min_iv[i] == 4 && max_iv[i] == 4, $sformatf("R5 out%0d spacing", i), max_iv[i], 4);
        end
        3: begin
          chk(tclk_oe[i] == 1'b1, $sformatf("R6 R2 out%0d oe", i), int'(tclk_oe[i]), 1);
          chk(rises[i] == 256, $sformatf("R6 R2 out%0d edges", i), rises[i], 256);
          chk(min_iv[i] >= 37, $sformatf("R6 out%0d min spacing", i), min_iv[i], 37);
          chk(max_iv[i] <= 38, $sformatf("R6 out%0d max spacing", i), max_iv[i], 38);
        end
        default: begin
          chk(tclk_oe[i] == 1'b1, $sformatf("R4 R7 R2 out%0d oe code %0d", i, code), int'(tclk_oe[i]), 1);
          chk(rises[i] == 1, $sformatf("R4 R7 R2 out%0d edges code %0d", i, code), rises[i], 1);
          chk(highs[i] == FRAME / 2, $sformatf("R4 R7 out%0d high cycles", i), highs[i], FRAME / 2);
        end
      endcase
    end
  endtask

  // R8: change applied only at the 8 kHz boundary
  task automatic t_boundary();
    int early = 0;
    int seen  = 0;
    logic prev_a;
    sel_word = 16'h0001;
    repeat (2 * FRAME + 10) @(negedge clk_ref);
    repeat (3000) @(negedge clk_ref);
    sel_word = 16'h0021;
    prev_a = tclk_o[0];
    for (int c = 0; c < FRAME + 10 && seen == 0; c++) begin
      @(negedge clk_ref);
      if (tclk_o[0] && !prev_a) begin
        seen = 1;
        chk(tclk_oe[1] == 1'b1, "R8 oe switches with 8k rise", int'(tclk_oe[1]), 1);
      end else if (tclk_oe[1] || tclk_o[1]) begin
        early++;
      end
      prev_a = tclk_o[0];
    end
    chk(seen == 1, "R8 boundary seen", seen, 1);
    chk(early == 0, "R8 no early switch", early, 0);
  endtask

  initial begin
    t_reset();
    t_pattern(16'h7321);
    t_pattern(16'h0F02);
    t_boundary();
    t_pattern(16'h0000);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk_ref);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule